// File: doc/BRIEF.md
# Handshaking Parallel Peripheral Port

This block connects a host bus to a set of 8-bit parallel peripheral ports, two by default (port A at index 0, port B at index 1). Each port holds an output latch, a per-bit direction register and a small control register. Software sets each pin to drive or to sense. It writes output values and reads back a mix of latched outputs and sampled inputs. Pad tristate control leaves the block as a separate output-enable vector, one bit per pin.

On top of plain I/O, each port runs an input handshake. A rising edge on the port's strobe line captures the pin values and sets a strobe flag. That flag drives the port's acknowledge output high and, when the port's interrupt enable is set, pulls its registered active-low interrupt request low. When the host reads that port's data register, the flag clears. This returns the acknowledge low, telling the peripheral that it may send more, and releases the interrupt. Every port has its own request line, so each can be serviced by a separate handler.

The bus side is synchronous. A read or write takes effect at the rising clock edge while chip select and the read or write line are high. Read data is combinational and is zero unless a read is in progress. The address is `{port index, register select}`, with the register select in the two low bits: 0 = data, 1 = direction, 2 = control, 3 = unused.

Top module: `pio_handshake`

## Requirements
- R1: Reset (synchronous, active high) clears every register: all pins become inputs (`pin_oe` = 0), `pin_out` = 0, every `ack_out` = 0, every `irq_n` = 1, and the control register reads 0.
- R2: Writing the direction register (select 1) sets `pin_oe` for that port from the next cycle. Bit value 1 means output and 0 means input. `pin_oe` changes on no other cycle.
- R3: Writing the data register (select 0) loads the output latch, which appears on `pin_out` from the next cycle. For output bits, a data read returns the latched value.
- R4: With capture mode off (control bit 1 = 0), a data read returns the live `pin_in` value for input bits.
- R5: A strobe rising edge (high now, low in the previous cycle) captures `pin_in` and sets the strobe flag, so `ack_out` is high from the next cycle. With capture mode on (control bit 1 = 1), a data read returns the captured value for input bits. A strobe held high does not capture again.
- R6: `irq_n` is registered and is low exactly when the strobe flag is set and the interrupt enable (control bit 0) is 1. With the enable at 0, the flag still sets and `irq_n` stays high. Setting the enable while the flag is set drives `irq_n` low from the next cycle.
- R7: A data-register read clears that port's flag, so `ack_out` goes low and `irq_n` goes high from the next cycle. Reading the direction or control register clears nothing.
- R8: If a strobe edge and a data read of the same port fall on the same clock edge, the strobe wins and the flag stays set.
- R9: Each port's strobe, flag, acknowledge and interrupt act independently of every other port.
- R10: Register select 3 reads as 0 and ignores writes. With chip select low, read and write lines are ignored.
- R11: The control register reads the strobe flag in bit 7 (read-only; a write does not change it), the capture mode in bit 1 and the enable in bit 0. Bits 2 to 6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe, sampled with chip select |
| bus_wr | input | 1 | Write strobe, sampled with chip select |
| bus_addr | input | 3 | Port index (bit 2) and register select (bits 1:0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read is in progress |
| pin_in | input | 16 | Pin values, port A in bits 7:0, port B in bits 15:8 |
| pin_out | output | 16 | Latched output values per pin |
| pin_oe | output | 16 | Per-pin output enable (direction register) |
| stb_in | input | 2 | Input strobe per port |
| ack_out | output | 2 | Acknowledge per port |
| irq_n | output | 2 | Active-low interrupt request per port |

## Verification
The bench targets the meeting points of the handshake. A design that recaptured on a held strobe level would raise the acknowledge again right after the clearing read. A design that cleared the flag on a control-register read would lose the event before the handler saw it. A design that let a same-edge read beat a new strobe would drop that strobe without a trace. The bench also mixes direction bits within one byte to catch a read mux that picks the wrong source per bit. It checks that an enable written after the event still raises the request, since a design that evaluated the enable only at strobe time would leave the request high.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CAP_BIT = 1;

    typedef struct packed {
        logic cap_mode;
        logic irq_en;
    } ctrl_t;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } port_req_t;

    function automatic int psel_width(input int nports);
        return (nports > 1) ? $clog2(nports) : 1;
    endfunction

endpackage

// File: rtl/pio_edge.sv
module pio_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  port_req_t    req,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pins,
    input  logic         stb,
    output logic [W-1:0] rdata,
    output logic [W-1:0] pout,
    output logic [W-1:0] poe,
    output logic         ack,
    output logic         irq_n
);
    logic [W-1:0] dir_q, out_q, cap_q;
    ctrl_t        ctrl_q, ctrl_d;
    logic         flag_q, flag_d, irq_n_q;
    logic         rise;
    logic         wr_data, wr_dir, wr_ctrl, rd_data;
    logic [W-1:0] in_view, data_view, ctrl_view;

    pio_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (stb),
        .rise (rise)
    );

    assign wr_data = req.wr && (req.sel == SEL_DATA);
    assign wr_dir  = req.wr && (req.sel == SEL_DIR);
    assign wr_ctrl = req.wr && (req.sel == SEL_CTRL);
    assign rd_data = req.rd && (req.sel == SEL_DATA);

    // a strobe edge outranks a clearing read on the same edge
    always_comb begin
        flag_d = flag_q;
        if (rd_data) flag_d = 1'b0;
        if (rise)    flag_d = 1'b1;
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.cap_mode = wdata[CTRL_CAP_BIT];
            ctrl_d.irq_en   = wdata[CTRL_EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            out_q   <= '0;
            cap_q   <= '0;
            ctrl_q  <= '0;
            flag_q  <= 1'b0;
            irq_n_q <= 1'b1;
        end else begin
            if (wr_dir)  dir_q <= wdata;
            if (wr_data) out_q <= wdata;
            if (rise)    cap_q <= pins;
            ctrl_q  <= ctrl_d;
            flag_q  <= flag_d;
            irq_n_q <= ~(flag_d & ctrl_d.irq_en);
        end
    end

    assign in_view   = ctrl_q.cap_mode ? cap_q : pins;
    assign data_view = (out_q & dir_q) | (in_view & ~dir_q);

    always_comb begin
        ctrl_view               = '0;
        ctrl_view[W-1]          = flag_q;
        ctrl_view[CTRL_CAP_BIT] = ctrl_q.cap_mode;
        ctrl_view[CTRL_EN_BIT]  = ctrl_q.irq_en;
    end

    always_comb begin
        rdata = '0;
        if (req.rd) begin
            case (req.sel)
                SEL_DATA: rdata = data_view;
                SEL_DIR:  rdata = dir_q;
                SEL_CTRL: rdata = ctrl_view;
                default:  rdata = '0;
            endcase
        end
    end

    assign pout  = out_q;
    assign poe   = dir_q;
    assign ack   = flag_q;
    assign irq_n = irq_n_q;
endmodule

// File: rtl/pio_handshake.sv
module pio_handshake
    import pio_pkg::*;
#(
    parameter int W      = 8,
    parameter int NPORTS = 2,
    localparam int PSEL_W = psel_width(NPORTS),
    localparam int ADDR_W = PSEL_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_cs,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [W-1:0]        bus_wdata,
    output logic [W-1:0]        bus_rdata,
    input  logic [NPORTS*W-1:0] pin_in,
    output logic [NPORTS*W-1:0] pin_out,
    output logic [NPORTS*W-1:0] pin_oe,
    input  logic [NPORTS-1:0]   stb_in,
    output logic [NPORTS-1:0]   ack_out,
    output logic [NPORTS-1:0]   irq_n
);
    port_req_t    req   [NPORTS];
    logic [W-1:0] prdata[NPORTS];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic hit;
        assign hit = bus_cs && (bus_addr[ADDR_W-1:2] == PSEL_W'(p));
        assign req[p] = '{rd:  hit && bus_rd,
                          wr:  hit && bus_wr,
                          sel: reg_sel_e'(bus_addr[1:0])};

        pio_port #(.W(W)) u_port (
            .clk   (clk),
            .rst   (rst),
            .req   (req[p]),
            .wdata (bus_wdata),
            .pins  (pin_in[p*W +: W]),
            .stb   (stb_in[p]),
            .rdata (prdata[p]),
            .pout  (pin_out[p*W +: W]),
            .poe   (pin_oe[p*W +: W]),
            .ack   (ack_out[p]),
            .irq_n (irq_n[p])
        );
    end

    // only the addressed port returns nonzero data
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORTS; p++) bus_rdata = bus_rdata | prdata[p];
    end
endmodule

// File: rtl/pio_handshake_chk.sv
module pio_handshake_chk
    import pio_pkg::*;
#(
    parameter int W      = 8,
    parameter int NPORTS = 2,
    localparam int PSEL_W = psel_width(NPORTS),
    localparam int ADDR_W = PSEL_W + 2
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_cs,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [W-1:0]        bus_rdata,
    input logic [NPORTS*W-1:0] pin_out,
    input logic [NPORTS*W-1:0] pin_oe,
    input logic [NPORTS-1:0]   stb_in,
    input logic [NPORTS-1:0]   ack_out,
    input logic [NPORTS-1:0]   irq_n
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (irq_n == '1 && ack_out == '0 && pin_oe == '0 && pin_out == '0));

    p_oe_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(bus_cs && bus_wr) |=> $stable(pin_oe));

    p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(bus_cs && bus_wr) |=> $stable(pin_out));

    p_unused_sel_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_cs && bus_rd && bus_addr[1:0] == 2'b11) |-> bus_rdata == '0);

    for (genvar i = 0; i < NPORTS; i++) begin : g_chk
        p_rise_ack_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(stb_in[i]) |=> ack_out[i]);

        p_irq_has_ack_r6: assert property (@(posedge clk) disable iff (rst)
            !irq_n[i] |-> ack_out[i]);

        p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
            (bus_cs && bus_rd && bus_addr[ADDR_W-1:2] == PSEL_W'(i) &&
             bus_addr[1:0] == 2'b00 && !stb_in[i])
            |=> (!ack_out[i] && irq_n[i]));
    end
endmodule

bind pio_handshake pio_handshake_chk #(.W(W), .NPORTS(NPORTS)) u_chk (.*);

// File: tb/pio_handshake_test.sv
module pio_handshake_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic [1:0]  stb_in = '0;
    logic [1:0]  ack_out, irq_n;

    int total = 0;
    int bad   = 0;

    pio_handshake uut (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .stb_in(stb_in), .ack_out(ack_out), .irq_n(irq_n)
    );

    always #(PERIOD/2) clk = ~clk;

    // port, direction, output value, pin value, expected data read
    localparam logic [32:0] TBL [4] = '{
        {1'b0, 8'h00, 8'hFF, 8'h5A, 8'h5A},
        {1'b1, 8'hFF, 8'h3C, 8'hA5, 8'h3C},
        {1'b0, 8'hF0, 8'h9F, 8'h12, 8'h92},
        {1'b1, 8'h0F, 8'h96, 8'hE7, 8'hE6}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_cs = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", pin_oe, 16'h0000);
        check("R1 pin_out", pin_out, 16'h0000);
        check("R1 irq_n", irq_n, 2'b11);
        check("R1 ack_out", ack_out, 2'b00);
        bus_read(3'b0_10, rv);
        check("R1 ctrl A", rv, 8'h00);

        // R2 R3 R4 table walk
        foreach (TBL[k]) begin
            logic [32:0] e;
            logic        p;
            e = TBL[k];
            p = e[32];
            bus_write({p, 2'b01}, e[31:24]);
            bus_write({p, 2'b00}, e[23:16]);
            if (p) pin_in[15:8] = e[15:8];
            else   pin_in[7:0]  = e[15:8];
            bus_read({p, 2'b00}, rv);
            check("R3 R4 data read", rv, e[7:0]);
            check("R2 pin_oe", p ? pin_oe[15:8] : pin_oe[7:0], e[31:24]);
            check("R3 pin_out", p ? pin_out[15:8] : pin_out[7:0], e[23:16]);
        end

        // R10 chip select low ignored, select 3 ignored
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b1; bus_addr = 3'b0_00; bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10 cs low write", pin_out[7:0], 8'h9F);
        bus_write(3'b0_11, 8'h55);
        check("R10 sel3 dir", pin_oe[7:0], 8'hF0);
        check("R10 sel3 out", pin_out[7:0], 8'h9F);
        bus_read(3'b0_11, rv);
        check("R10 sel3 read", rv, 8'h00);

        // R11 control bits read back
        bus_write(3'b0_10, 8'hFF);
        bus_read(3'b0_10, rv);
        check("R11 ctrl readback", rv, 8'h03);

        // R5 R6 R7 R9 handshake on port A, enable and capture mode on
        bus_write(3'b0_01, 8'h00);
        pin_in[7:0] = 8'hC3;
        @(negedge clk);
        stb_in[0] = 1'b1;
        @(negedge clk);
        check("R5 ack A", ack_out[0], 1'b1);
        check("R6 irq A", irq_n[0], 1'b0);
        check("R9 ack B idle", ack_out[1], 1'b0);
        check("R9 irq B idle", irq_n[1], 1'b1);
        pin_in[7:0] = 8'h00;
        bus_read(3'b0_10, rv);
        check("R11 flag bit", rv, 8'h83);
        check("R7 ctrl read keeps ack", ack_out[0], 1'b1);
        bus_read(3'b0_00, rv);
        check("R5 captured value", rv, 8'hC3);
        check("R7 ack cleared", ack_out[0], 1'b0);
        check("R7 irq released", irq_n[0], 1'b1);
        @(negedge clk);
        check("R5 held level no recapture", ack_out[0], 1'b0);
        stb_in[0] = 1'b0;

        // R6 enable off on port B, live mode
        bus_write(3'b1_01, 8'h00);
        pin_in[15:8] = 8'h5A;
        @(negedge clk);
        stb_in[1] = 1'b1;
        @(negedge clk);
        check("R6 ack B", ack_out[1], 1'b1);
        check("R6 irq B masked", irq_n[1], 1'b1);
        bus_read(3'b1_10, rv);
        check("R6 flag B set", rv, 8'h80);
        bus_write(3'b1_10, 8'h01);
        check("R6 late enable", irq_n[1], 1'b0);
        check("R9 port A quiet", {ack_out[0], irq_n[0]}, 2'b01);
        bus_read(3'b1_00, rv);
        check("R4 live read B", rv, 8'h5A);
        check("R7 ack B cleared", ack_out[1], 1'b0);
        check("R7 irq B released", irq_n[1], 1'b1);
        stb_in[1] = 1'b0;

        // R8 strobe edge and clearing read on the same edge
        @(negedge clk);
        stb_in[0] = 1'b1;
        bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = 3'b0_00;
        @(negedge clk);
        bus_cs = 1'b0; bus_rd = 1'b0;
        check("R8 ack survives", ack_out[0], 1'b1);
        check("R8 irq survives", irq_n[0], 1'b0);
        bus_read(3'b0_00, rv);
        check("R5 second capture", rv, 8'h00);
        check("R7 cleared after R8", ack_out[0], 1'b0);
        stb_in[0] = 1'b0;

        // R1 reset in mid run
        bus_write(3'b0_01, 8'hAA);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 oe after reset", pin_oe, 16'h0000);
        check("R1 out after reset", pin_out, 16'h0000);
        check("R1 irq after reset", irq_n, 2'b11);
        check("R1 ack after reset", ack_out, 2'b00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule